// File: doc/BRIEF.md
# Double-Buffered Endpoint Receive Port

This block is the receive buffer of one USB pipe. It sits between the serial interface engine (SIE), which writes received packets, and a CPU register port, which reads those packets one word at a time. Storage is split into one or two planes. At any time each plane is owned by either the SIE side or the CPU side. When the SIE finishes a packet, ownership of that plane passes to the CPU. When the CPU has read the packet, or clears it, ownership passes back to the SIE.

The CPU sees a port-ready flag, the word count of the visible packet, a read strobe with its data, and a clear command. The flag can be high while nothing is left to read: after a zero-length packet, and after a short packet has been read out while buffer-ready-interrupt mode is on. In both cases the CPU has to clear the plane. A control-pipe mode always uses a single plane. In that mode the clear command can also discard a partly filled plane that the SIE owns, but only while the handshake response is forced to NAK.

Top module: `ep_fifo_port`

## Requirements
- R1: After reset the port-ready flag is 0, the SIE busy flag is 0 and the visible word count is 0.
- R2: A packet end accepted from the SIE raises the ready flag on the cycle after the edge that takes it. The visible count equals the number of words written, and any write beyond DEPTH words is dropped.
- R3: Each read strobe, while ready is 1 and words remain, returns the next word in the order it was written, in the same cycle. A read while ready is 0, or with no word left, returns 0 and changes no state.
- R4: When the CPU has read the last word of a DEPTH-word packet, the plane returns to the SIE. In single-plane mode, ready and busy are both 0 on the next cycle.
- R5: In double mode the SIE fills the planes alternately. Busy is 1 while the plane next in line is CPU-owned, and writes and packet ends are ignored while busy is 1. When a plane is released, the other plane, if it holds a packet, becomes the readable one with no gap in ready.
- R6: In double mode a clear releases only the plane currently readable, even when both planes hold packets.
- R7: On a non-control pipe, a clear issued while ready is 0 is ignored. Words the SIE has already written to its plane are kept.
- R8: A zero-length packet sets ready to 1 with a count of 0. Reads return 0, and ready stays 1 until a clear.
- R9: A packet shorter than DEPTH words that has been read out is released automatically when buffer-ready-interrupt mode is 0. When that mode is 1, ready stays at 1, further reads return 0, and a clear is needed.
- R10: In control-pipe mode only one plane is used, whatever the double-mode input says. A clear while ready is 0 discards the SIE's partial data only while nak_i is 1, and otherwise leaves that data untouched. A clear while ready is 1 releases the CPU plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_mode_i | input | 1 | Use two planes (ignored on a control pipe); static between resets |
| ctrl_pipe_i | input | 1 | Pipe is the control pipe; static between resets |
| nak_i | input | 1 | Handshake response forced to NAK (control pipe) |
| bfre_i | input | 1 | Buffer-ready-interrupt mode; static between resets |
| sie_wr_i | input | 1 | SIE writes one word |
| sie_data_i | input | DW | SIE write data |
| sie_end_i | input | 1 | SIE packet end; alone it signals a zero-length packet |
| sie_busy_o | output | 1 | No SIE-owned plane is free (NAK to host) |
| rd_i | input | 1 | CPU read strobe |
| rd_data_o | output | DW | Read data, valid in the strobe cycle |
| rd_cnt_o | output | CW | Word count of the readable packet, 0 when not ready |
| bclr_i | input | 1 | CPU clear command |
| frdy_o | output | 1 | Port ready |

## Verification
Read data is combinational and belongs to the same cycle as the read strobe. The ready flag, busy flag and visible count all change one cycle after the edge that takes a packet end, a final read or a clear. The bench changes inputs 1 ns after each rising edge and samples every output at the following falling edge. At that point a read strobe shows its data, and a strobe taken at the previous rising edge already shows its effect on the flags. A behavioural model updates at each rising edge from the same inputs and is compared at every falling edge. Directed checks sample at the falling edge of an idle cycle after each action.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  typedef enum logic {
    OWN_SIE = 1'b0,
    OWN_CPU = 1'b1
  } owner_e;
endpackage

// File: rtl/ep_plane.sv
module ep_plane #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          push;

  assign full = (cnt_q == CW'(DEPTH));
  assign push = wr_i && !full && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (push)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[AW'(cnt_q)] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ep_owner_ctl.sv
module ep_owner_ctl
  import ep_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dbl_i,
  input  logic                ctrl_i,
  input  logic                nak_i,
  input  logic                bfre_i,
  input  logic                sie_wr_i,
  input  logic                sie_end_i,
  input  logic                rd_i,
  input  logic                bclr_i,
  input  logic [1:0][CW-1:0]  cnt_i,
  output logic [1:0]          plane_wr_o,
  output logic [1:0]          plane_clr_o,
  output logic                rd_sel_o,
  output logic [AW-1:0]       raddr_o,
  output logic                rd_hit_o,
  output logic                frdy_o,
  output logic                busy_o
);
  owner_e        own_q [2];
  logic          rd_sel_q, fill_sel_q;
  logic [CW-1:0] rptr_q;
  logic [CW-1:0] cur_cnt;
  logic          dbl, last_rd, short_pkt, release_pl, sie_clr, sie_ok, commit;

  assign dbl        = dbl_i & ~ctrl_i;  // control pipe is single-plane
  assign frdy_o     = (own_q[rd_sel_q] == OWN_CPU);
  assign busy_o     = (own_q[fill_sel_q] == OWN_CPU);
  assign cur_cnt    = cnt_i[rd_sel_q];
  assign rd_hit_o   = rd_i & frdy_o & (rptr_q < cur_cnt);
  assign last_rd    = rd_hit_o & (CW'(rptr_q + 1'b1) == cur_cnt);
  assign short_pkt  = (cur_cnt != CW'(DEPTH));
  assign release_pl = (last_rd & (~short_pkt | ~bfre_i)) | (bclr_i & frdy_o);
  assign sie_clr    = bclr_i & ctrl_i & ~frdy_o & nak_i;
  assign sie_ok     = ~busy_o & ~sie_clr;
  assign commit     = sie_end_i & sie_ok;
  assign rd_sel_o   = rd_sel_q;
  assign raddr_o    = AW'(rptr_q);

  always_comb begin
    plane_wr_o  = '0;
    plane_clr_o = '0;
    plane_wr_o[fill_sel_q]  = sie_wr_i & sie_ok;
    plane_clr_o[rd_sel_q]   = release_pl;
    if (sie_clr) plane_clr_o[fill_sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) own_q[i] <= OWN_SIE;
      rd_sel_q   <= 1'b0;
      fill_sel_q <= 1'b0;
      rptr_q     <= '0;
    end else begin
      if (commit) begin
        own_q[fill_sel_q] <= OWN_CPU;
        fill_sel_q        <= dbl ? ~fill_sel_q : 1'b0;
      end
      if (release_pl) begin
        own_q[rd_sel_q] <= OWN_SIE;
        rptr_q          <= '0;
        rd_sel_q        <= dbl ? ~rd_sel_q : 1'b0;
      end else if (rd_hit_o) begin
        rptr_q <= rptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep_fifo_port.sv
module ep_fifo_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbl_mode_i,
  input  logic          ctrl_pipe_i,
  input  logic          nak_i,
  input  logic          bfre_i,
  input  logic          sie_wr_i,
  input  logic [DW-1:0] sie_data_i,
  input  logic          sie_end_i,
  output logic          sie_busy_o,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] rd_cnt_o,
  input  logic          bclr_i,
  output logic          frdy_o
);
  logic [1:0][CW-1:0] cnt;
  logic [1:0][DW-1:0] rdata;
  logic [1:0]         plane_wr, plane_clr;
  logic               rd_sel, rd_hit;
  logic [AW-1:0]      raddr;

  ep_owner_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbl_i      (dbl_mode_i),
    .ctrl_i     (ctrl_pipe_i),
    .nak_i      (nak_i),
    .bfre_i     (bfre_i),
    .sie_wr_i   (sie_wr_i),
    .sie_end_i  (sie_end_i),
    .rd_i       (rd_i),
    .bclr_i     (bclr_i),
    .cnt_i      (cnt),
    .plane_wr_o (plane_wr),
    .plane_clr_o(plane_clr),
    .rd_sel_o   (rd_sel),
    .raddr_o    (raddr),
    .rd_hit_o   (rd_hit),
    .frdy_o     (frdy_o),
    .busy_o     (sie_busy_o)
  );

  for (genvar p = 0; p < 2; p++) begin : g_plane
    ep_plane #(.DW(DW), .DEPTH(DEPTH)) u_plane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (plane_wr[p]),
      .wdata_i(sie_data_i),
      .clr_i  (plane_clr[p]),
      .raddr_i(raddr),
      .rdata_o(rdata[p]),
      .cnt_o  (cnt[p])
    );
  end

  assign rd_data_o = rd_hit ? rdata[rd_sel] : '0;
  assign rd_cnt_o  = frdy_o ? cnt[rd_sel] : '0;
endmodule

// File: rtl/ep_fifo_port_chk.sv
module ep_fifo_port_chk #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dbl_mode_i,
  input logic          ctrl_pipe_i,
  input logic          sie_end_i,
  input logic          sie_busy_o,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic [CW-1:0] rd_cnt_o,
  input logic          bclr_i,
  input logic          frdy_o
);
  assert_commit_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sie_end_i && !sie_busy_o && !bclr_i) |=> frdy_o);

  assert_idle_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frdy_o) |-> (rd_data_o == '0));

  assert_busy_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_busy_o |-> frdy_o);

  assert_clear_one_plane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_mode_i && !ctrl_pipe_i && bclr_i && sie_busy_o) |=> frdy_o);

  assert_zlp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frdy_o && rd_cnt_o == '0 && !bclr_i) |=> frdy_o);
endmodule

bind ep_fifo_port ep_fifo_port_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbl_mode_i (dbl_mode_i),
  .ctrl_pipe_i(ctrl_pipe_i),
  .sie_end_i  (sie_end_i),
  .sie_busy_o (sie_busy_o),
  .rd_i       (rd_i),
  .rd_data_o  (rd_data_o),
  .rd_cnt_o   (rd_cnt_o),
  .bclr_i     (bclr_i),
  .frdy_o     (frdy_o)
);

// File: tb/ep_fifo_port_bench.sv
`timescale 1ns/100ps
module ep_fifo_port_bench;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dbl = 0, ctrl = 0, nak = 0, bfre = 0;
  logic sie_wr = 0, sie_end = 0, rd = 0, bclr = 0;
  logic [DW-1:0] sie_data = '0;
  logic sie_busy, frdy;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep_fifo_port #(.DW(DW), .DEPTH(DEPTH)) u_ep_fifo_port (
    .clk_i(clk), .rst_ni(rst_n), .dbl_mode_i(dbl), .ctrl_pipe_i(ctrl),
    .nak_i(nak), .bfre_i(bfre), .sie_wr_i(sie_wr), .sie_data_i(sie_data),
    .sie_end_i(sie_end), .sie_busy_o(sie_busy), .rd_i(rd), .rd_data_o(rd_data),
    .rd_cnt_o(rd_cnt), .bclr_i(bclr), .frdy_o(frdy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_mem [2][DEPTH];
  int m_cnt [2];
  bit m_own [2];
  int m_rp, m_rs, m_fs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '{0, 0}; m_own = '{0, 0}; m_rp = 0; m_rs = 0; m_fs = 0;
    end else begin
      bit b_dbl, b_rdy, b_busy, b_hit, b_last, b_rel, b_sclr;
      int cc, nfs;
      b_dbl  = dbl && !ctrl;
      b_rdy  = m_own[m_rs];
      b_busy = m_own[m_fs];
      cc     = m_cnt[m_rs];
      b_hit  = rd && b_rdy && m_rp < cc;
      b_last = b_hit && (m_rp + 1 == cc);
      b_rel  = (b_last && (cc == DEPTH || !bfre)) || (bclr && b_rdy);
      b_sclr = bclr && ctrl && !b_rdy && nak;
      nfs = m_fs;
      if (b_sclr) m_cnt[m_fs] = 0;
      else if (!b_busy) begin
        if (sie_wr && m_cnt[m_fs] < DEPTH) begin
          m_mem[m_fs][m_cnt[m_fs]] = int'(sie_data);
          m_cnt[m_fs]++;
        end
        if (sie_end) begin
          m_own[m_fs] = 1;
          nfs = b_dbl ? 1 - m_fs : 0;
        end
      end
      if (b_rel) begin
        m_own[m_rs] = 0; m_cnt[m_rs] = 0; m_rp = 0;
        m_rs = b_dbl ? 1 - m_rs : 0;
      end else if (b_hit) m_rp++;
      m_fs = nfs;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_data;
      e_data = (rd && m_own[m_rs] && m_rp < m_cnt[m_rs]) ? m_mem[m_rs][m_rp] : 0;
      chk("R2 model ready", int'(frdy), int'(m_own[m_rs]));
      chk("R5 model busy", int'(sie_busy), int'(m_own[m_fs]));
      chk("R2 model count", int'(rd_cnt), m_own[m_rs] ? m_cnt[m_rs] : 0);
      chk("R3 model data", int'(rd_data), e_data);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    sie_wr = 0; sie_end = 0; rd = 0; bclr = 0; sie_data = '0;
  endtask

  task automatic idle();
    step();
    @(negedge clk);
  endtask

  task automatic do_reset(bit d, bit c, bit b);
    @(posedge clk); #1;
    rst_n = 0; dbl = d; ctrl = c; bfre = b; nak = 0;
    sie_wr = 0; sie_end = 0; rd = 0; bclr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_words(int n, int base);
    for (int i = 0; i < n; i++) begin
      step(); sie_wr = 1; sie_data = DW'(base + i);
    end
    idle();
  endtask

  task automatic send_pkt(int n, int base);
    if (n == 0) begin
      step(); sie_end = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        step(); sie_wr = 1; sie_data = DW'(base + i); sie_end = (i == n - 1);
      end
    end
    idle();
  endtask

  task automatic rd_word(output int d);
    step(); rd = 1;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic clear();
    step(); bclr = 1;
    idle();
  endtask

  task automatic read_expect(string tag, int n, int base);
    int d;
    for (int i = 0; i < n; i++) begin
      rd_word(d);
      chk(tag, d, base + i);
    end
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d;
    // single plane, normal pipe
    do_reset(0, 0, 0);
    chk("R1 ready", int'(frdy), 0);
    chk("R1 busy", int'(sie_busy), 0);
    chk("R1 count", int'(rd_cnt), 0);
    rd_word(d); chk("R3 read when not ready", d, 0);
    idle(); chk("R3 ready unchanged", int'(frdy), 0);

    wr_words(2, 'h10);
    clear();                           // R7: ignored, ready is 0
    send_pkt(1, 'h12);
    chk("R7 partial data kept", int'(rd_cnt), 3);
    read_expect("R3 word order", 3, 'h10);
    chk("R9 short auto release", int'(frdy), 0);

    send_pkt(4, 'h20);
    chk("R2 ready", int'(frdy), 1);
    chk("R2 count", int'(rd_cnt), 4);
    chk("R5 busy single", int'(sie_busy), 1);
    send_pkt(2, 'h30);                 // ignored while busy
    chk("R5 busy write ignored", int'(rd_cnt), 4);
    read_expect("R4 full packet data", 4, 'h20);
    chk("R4 ready after full read", int'(frdy), 0);
    chk("R4 busy after full read", int'(sie_busy), 0);

    send_pkt(0, 0);
    chk("R8 zlp ready", int'(frdy), 1);
    chk("R8 zlp count", int'(rd_cnt), 0);
    rd_word(d); chk("R8 zlp read", d, 0);
    idle(); chk("R8 zlp held", int'(frdy), 1);
    clear(); chk("R8 zlp cleared", int'(frdy), 0);

    send_pkt(6, 'h40);
    chk("R2 overflow dropped", int'(rd_cnt), 4);
    read_expect("R2 overflow data", 4, 'h40);

    // buffer-ready-interrupt mode
    do_reset(0, 0, 1);
    send_pkt(2, 'h50);
    read_expect("R9 short data", 2, 'h50);
    chk("R9 ready held", int'(frdy), 1);
    rd_word(d); chk("R9 read empty", d, 0);
    idle(); clear(); chk("R9 cleared", int'(frdy), 0);

    // double plane
    do_reset(1, 0, 0);
    send_pkt(4, 'h60);
    send_pkt(4, 'h70);
    chk("R5 busy both full", int'(sie_busy), 1);
    clear();
    chk("R6 other plane ready", int'(frdy), 1);
    chk("R6 other plane count", int'(rd_cnt), 4);
    chk("R6 busy freed", int'(sie_busy), 0);
    read_expect("R6 second plane data", 4, 'h70);
    chk("R6 all released", int'(frdy), 0);
    send_pkt(4, 'h80);
    send_pkt(2, 'h90);
    read_expect("R5 first plane data", 4, 'h80);
    chk("R5 handover ready", int'(frdy), 1);
    chk("R5 handover count", int'(rd_cnt), 2);
    read_expect("R5 second plane data", 2, 'h90);
    chk("R5 drained", int'(frdy), 0);

    // control pipe
    do_reset(1, 1, 0);
    wr_words(2, 'hA0);
    clear();
    send_pkt(1, 'hA2);
    chk("R10 no nak keeps data", int'(rd_cnt), 3);
    chk("R10 single plane busy", int'(sie_busy), 1);
    clear(); chk("R10 cpu clear", int'(frdy), 0);
    nak = 1;
    wr_words(2, 'hB0);
    clear();
    send_pkt(1, 'hB2);
    chk("R10 nak discards", int'(rd_cnt), 1);
    read_expect("R10 data after discard", 1, 'hB2);
    nak = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule